// File: doc/BRIEF.md
# Interrupt Router with Pending Latch, Masking and Priority Offset

This block collects a set of peripheral interrupt inputs, by default 21, and turns them into two request lines for a processor: a normal request line and a fast request line. Every rising edge on a source input is captured in a pending bit. A per-source route bit sends that source to one of the two lines. A per-source mask bit keeps a pending source from driving either line. One extra mask bit, placed just above the per-source bits, silences both lines at once.

Software reaches the state over a simple word-addressed register bus. It can read the route, pending and mask state. It clears pending bits by writing ones to them. Two read-only registers report the winning source for each line, as the source index times four. This gives a handler a ready-made table offset. Priority is fixed, and the highest source index wins.

Top module: `vic_top`

## Requirements
- R1: After a synchronous reset, every pending bit is 0 and every route bit is 0. Every mask bit, the global mask included, is 1. Both request outputs are low.
- R2: When a source input goes from 0 to 1 between two clock edges, its pending bit is set at that edge. A source held high sets its bit only once; after that bit is cleared, the held level does not set it again.
- R3: A write to the pending register (word address 1) clears each pending bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: If a rising edge and a write-1 clear reach the same pending bit in the same cycle, the bit ends up set.
- R5: A source whose mask bit is 1 stays pending, but it drives neither request output and is left out of both offset registers.
- R6: While the global mask bit (mask register bit NSRC, bit 21 by default) is 1, neither request output is asserted, whatever the pending state.
- R7: A route bit of 0 sends its source to the normal request output, and a route bit of 1 sends it to the fast request output. Each output is a register: it goes high one clock after a pending, unmasked source on its route exists while the global mask is 0.
- R8: The normal offset register (word address 3) reads as 4 times the highest index among pending, unmasked sources routed to the normal line. It reads NSRC*4 (0x54 by default) when there is no such source. It does not depend on the global mask.
- R9: The fast offset register (word address 4) follows the same rule as R8, using the sources routed to the fast line.
- R10: The register map uses word addresses: 0 route, 1 pending, 2 mask (NSRC+1 bits), 3 normal offset, 4 fast offset. Read data appears on the clock after the request. Unused bits and unused addresses read 0. Writes to addresses 3 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Interrupt source inputs |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the request |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with the default of 21 sources. With that value the global mask sits at bit 21, and the empty-offset value is exactly 0x54, so both corner cases are checked at their real positions. The directed cases cover edges at index 0 and index 20, the extreme priority positions. Random route, mask, clear and source patterns over the full 21-bit width then exercise priority contests between the two lines.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned BUS_AW = 3;
  localparam int unsigned BUS_DW = 32;
  localparam logic [BUS_AW-1:0] RA_ROUTE = 3'd0;
  localparam logic [BUS_AW-1:0] RA_PEND  = 3'd1;
  localparam logic [BUS_AW-1:0] RA_MASK  = 3'd2;
  localparam logic [BUS_AW-1:0] RA_NOFF  = 3'd3;
  localparam logic [BUS_AW-1:0] RA_FOFF  = 3'd4;
  typedef enum logic {ROUTE_NORM = 1'b0, ROUTE_FAST = 1'b1} route_e;
endpackage

// File: rtl/vic_pend_latch.sv
module vic_pend_latch #(
  parameter int unsigned NSRC = 21
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] rise_o,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] src_q;

  assign rise_o = src_i & ~src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      pend_o <= '0;
    end else begin
      src_q  <= src_i;
      // set has priority over clear
      pend_o <= (pend_o & ~clr_i) | rise_o;
    end
  end
endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
  parameter int unsigned NSRC  = 21,
  parameter int unsigned IDX_W = $clog2(NSRC + 1)
) (
  input  logic [NSRC-1:0]  req_i,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = IDX_W'(NSRC);
    for (int i = 0; i < NSRC; i++) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vic_regbank.sv
module vic_regbank
  import vic_pkg::*;
#(
  parameter int unsigned NSRC  = 21,
  parameter int unsigned OFF_W = $clog2(NSRC + 1) + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  input  logic [NSRC-1:0]   pend_i,
  input  logic [OFF_W-1:0]  noff_i,
  input  logic [OFF_W-1:0]  foff_i,
  output logic [NSRC-1:0]   route_o,
  output logic [NSRC:0]     mask_o,
  output logic [NSRC-1:0]   clr_o,
  output logic [BUS_DW-1:0] rdata_o
);
  logic wr;
  logic [BUS_DW-1:0] rd_mux;

  assign wr    = bus_en & bus_we;
  assign clr_o = (wr && bus_addr == RA_PEND) ? bus_wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      route_o <= '0;
      mask_o  <= '1;
    end else if (wr) begin
      if (bus_addr == RA_ROUTE) route_o <= bus_wdata[NSRC-1:0];
      if (bus_addr == RA_MASK)  mask_o  <= bus_wdata[NSRC:0];
    end
  end

  always_comb begin
    unique case (bus_addr)
      RA_ROUTE: rd_mux = BUS_DW'(route_o);
      RA_PEND:  rd_mux = BUS_DW'(pend_i);
      RA_MASK:  rd_mux = BUS_DW'(mask_o);
      RA_NOFF:  rd_mux = BUS_DW'(noff_i);
      RA_FOFF:  rd_mux = BUS_DW'(foff_i);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else if (bus_en && !bus_we) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int unsigned NSRC = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int unsigned IDX_W = $clog2(NSRC + 1);
  localparam int unsigned OFF_W = IDX_W + 2;
  localparam int unsigned NROUTE = 2;

  logic [NSRC-1:0] pend_q, rise_w, pend_clr, mode_q;
  logic [NSRC:0]   mask_q;
  logic [NSRC-1:0] live;
  logic [NROUTE-1:0][NSRC-1:0]  cand;
  logic [NROUTE-1:0][IDX_W-1:0] win;
  logic [NROUTE-1:0][OFF_W-1:0] off;
  logic [NROUTE-1:0] line_q;

  vic_pend_latch #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst(rst), .src_i(src_i), .clr_i(pend_clr),
    .rise_o(rise_w), .pend_o(pend_q)
  );

  assign live = pend_q & ~mask_q[NSRC-1:0];

  for (genvar r = 0; r < NROUTE; r++) begin : g_route
    if (r == int'(ROUTE_NORM)) begin : g_norm
      assign cand[r] = live & ~mode_q;
    end else begin : g_fast
      assign cand[r] = live & mode_q;
    end
    vic_prio_enc #(.NSRC(NSRC), .IDX_W(IDX_W)) u_enc (
      .req_i(cand[r]), .idx_o(win[r])
    );
    assign off[r] = {win[r], 2'b00};
    always_ff @(posedge clk) begin
      if (rst) line_q[r] <= 1'b0;
      else     line_q[r] <= (|cand[r]) & ~mask_q[NSRC];
    end
  end

  assign irq_o = line_q[int'(ROUTE_NORM)];
  assign fiq_o = line_q[int'(ROUTE_FAST)];

  vic_regbank #(.NSRC(NSRC), .OFF_W(OFF_W)) u_regs (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend_i(pend_q),
    .noff_i(off[int'(ROUTE_NORM)]), .foff_i(off[int'(ROUTE_FAST)]),
    .route_o(mode_q), .mask_o(mask_q), .clr_o(pend_clr), .rdata_o(bus_rdata)
  );
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
  parameter int unsigned NSRC = 21
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] rise,
  input logic [NSRC-1:0] clr,
  input logic [NSRC-1:0] mode,
  input logic [NSRC:0]   mask,
  input logic            irq,
  input logic            fiq
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pend == '0 && mode == '0 && mask == '1 && !irq && !fiq));

  a_r3_clear_takes: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & $past(clr & ~rise)) == '0));

  a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & $past(rise)) == $past(rise)));

  a_r6_global_quiet: assert property (@(posedge clk) disable iff (rst)
    mask[NSRC] |=> (!irq && !fiq));

  a_r7_irq_source: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|(pend & ~mask[NSRC-1:0] & ~mode)));

  a_r7_fiq_source: assert property (@(posedge clk) disable iff (rst)
    $rose(fiq) |-> $past(|(pend & ~mask[NSRC-1:0] & mode)));

  a_r2_pend_origin: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & ~$past(pend)) == (pend & $past(rise) & ~$past(pend))));
endmodule

bind vic_top vic_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst(rst), .pend(pend_q), .rise(rise_w), .clr(pend_clr),
  .mode(mode_q), .mask(mask_q), .irq(irq_o), .fiq(fiq_o)
);

// File: tb/sim_vic_top.sv
module sim_vic_top;
  localparam int NSRC = 21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NSRC-1:0] src = '0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_o, fiq_o;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [NSRC-1:0] m_pend = '0, m_mode = '0;
  logic [NSRC:0]   m_mask = '1;

  always #4 clk = ~clk;

  vic_top #(.NSRC(NSRC)) u0 (
    .clk(clk), .rst(rst), .src_i(src), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  function automatic logic [31:0] f_off(logic [NSRC-1:0] p, logic [NSRC:0] m,
                                        logic [NSRC-1:0] md, logic fast);
    int w = NSRC;
    for (int i = 0; i < NSRC; i++)
      if (p[i] && !m[i] && md[i] == fast) w = i;
    return 32'(w * 4);
  endfunction

  function automatic logic f_line(logic [NSRC-1:0] p, logic [NSRC:0] m,
                                  logic [NSRC-1:0] md, logic fast);
    logic any = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (p[i] && !m[i] && md[i] == fast) any = 1'b1;
    return any && !m[NSRC];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    if (a == 3'd0) m_mode = d[NSRC-1:0];
    if (a == 3'd1) m_pend = m_pend & ~d[NSRC-1:0];
    if (a == 3'd2) m_mask = d[NSRC:0];
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_en = 0;
    d = bus_rdata;
  endtask

  task automatic drive_src(logic [NSRC-1:0] v);
    @(negedge clk);
    m_pend = m_pend | (v & ~src);
    src = v;
    @(negedge clk);
  endtask

  task automatic check_all(string req);
    logic [31:0] d;
    @(negedge clk);
    chk({req, " R7 irq line"}, 32'(irq_o), 32'(f_line(m_pend, m_mask, m_mode, 1'b0)));
    chk({req, " R7 fiq line"}, 32'(fiq_o), 32'(f_line(m_pend, m_mask, m_mode, 1'b1)));
    rd(3'd0, d); chk({req, " R10 route"}, d, 32'(m_mode));
    rd(3'd1, d); chk({req, " R2 pending"}, d, 32'(m_pend));
    rd(3'd2, d); chk({req, " R10 mask"}, d, 32'(m_mask));
    rd(3'd3, d); chk({req, " R8 norm offset"}, d, f_off(m_pend, m_mask, m_mode, 1'b0));
    rd(3'd4, d); chk({req, " R9 fast offset"}, d, f_off(m_pend, m_mask, m_mode, 1'b1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    @(negedge clk);
    chk("R1 irq low", 32'(irq_o), 0);
    chk("R1 fiq low", 32'(fiq_o), 0);
    check_all("R1");
    chk("R1 empty offset 0x54", f_off(m_pend, m_mask, m_mode, 1'b0), 32'h54);

    // R6 global mask holds lines low while sources unmasked
    wr(3'd2, 32'h0020_0000);
    drive_src(21'h000005);
    check_all("R6");
    chk("R6 irq under global mask", 32'(irq_o), 0);

    // R7/R8 open global mask
    wr(3'd2, 32'h0);
    check_all("R8");
    chk("R8 offset idx2", f_off(m_pend, m_mask, m_mode, 1'b0), 32'h8);
    // R9 route source 2 to fast
    wr(3'd0, 32'h4);
    check_all("R9");
    // R3 clear bit0, write zero no effect
    wr(3'd1, 32'h1);
    wr(3'd1, 32'h0);
    check_all("R3");
    // R2 level held does not re-set
    repeat (3) @(negedge clk);
    check_all("R2 held");
    // R5 mask source 2
    wr(3'd2, 32'h4);
    check_all("R5");
    rd(3'd1, d); chk("R5 still pending", d & 32'h4, 32'h4);
    // R4 set wins, index 20
    wr(3'd2, 32'h0);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = 3'd1; bus_wdata = 32'h0010_0000;
    src = src | 21'h100000;
    m_pend = m_pend | 21'h100000;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
    check_all("R4");
    rd(3'd1, d); chk("R4 bit20 set", d & 32'h0010_0000, 32'h0010_0000);
    // R10 writes to offsets ignored, unused address reads zero
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    check_all("R10");
    rd(3'd7, d); chk("R10 unused addr", d, 0);

    // random mix
    for (int it = 0; it < 80; it++) begin
      int act = $urandom_range(0, 3);
      logic [31:0] r = $urandom;
      case (act)
        0: drive_src(r[NSRC-1:0]);
        1: wr(3'd0, r);
        2: wr(3'd2, r & ($urandom_range(0, 3) == 0 ? 32'h003F_FFFF : 32'h001F_FFFF));
        default: wr(3'd1, r);
      endcase
      check_all("RND");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule